// File: doc/BRIEF.md
# Soft-Start Power-Up Sequencer

This block sequences the start of a two-phase buck converter, counting time in switching cycles. A one-clock tick marks each switching cycle. A supply-ready state is built from two comparator flags, one meaning the supply has passed the upper threshold and one meaning it has dropped under the lower threshold. While that state is clear, every phase output is held in high impedance.

Once the supply is ready, a high-to-low transition on the active-low enable starts a run of three intervals. First, every phase stays in high impedance with the reference held at zero. Next, every phase is forced low for a programmable number of cycles, which clamps the lower switches. Last, every phase switches while the reference code and the duty-cycle ceiling climb from zero to full scale. Power-good rises at a fixed cycle count, and by then both ramps have reached full scale. Losing the supply or raising the enable at any time returns the block to idle.

Top module: `softstart_seq`

## Requirements
- R1: During and right after reset, every phase mode is high impedance (code 00), `ref_code` and `duty_max` are zero and `pwr_good` is low.
- R2: The supply-ready state is set on a clock where `sup_above_rise` is high and cleared on a clock where `sup_below_fall` is high, and clearing takes priority. A high `sup_below_fall` during a run returns the block to idle at the next clock edge.
- R3: A run starts only on a clock where `en_n` is low after being high on the previous clock, with supply ready and `sup_below_fall` low. An enable that is already low when the supply becomes ready starts nothing.
- R4: Let k be the number of ticks seen since the start. While k < 64, every phase is high impedance (code 00) and `ref_code` and `duty_max` are zero.
- R5: While 64 <= k < 64+CLAMP_CYC (default 300), every phase is forced low (code 01).
- R6: From k = 64+CLAMP_CYC on, every phase is in switching mode (code 10). All phases always carry the same code, packed two bits per phase with phase p at bits [2p+1:2p].
- R7: In the ramp interval, `ref_code` = min((k-364) >> 3, 255) with default parameters, rising by at most one code per tick.
- R8: In the ramp interval, `duty_max` = min((k-364) >> 4, 63) with default parameters.
- R9: `pwr_good` is high exactly when k has reached 4096. It then stays high for the rest of the run, with `ref_code` at full scale.
- R10: `en_n` high during a run returns the block to idle and clears `pwr_good` at the next clock edge.
- R11: k advances only on clocks where `tick` is high and saturates at 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-clock pulse per switching cycle |
| sup_above_rise | input | 1 | Supply above upper threshold |
| sup_below_fall | input | 1 | Supply below lower threshold |
| en_n | input | 1 | Active-low enable; falling edge starts a run |
| ph_mode | output | 2*NPH | Per-phase mode: 00 high impedance, 01 forced low, 10 switching |
| ref_code | output | REF_W | Reference DAC code |
| duty_max | output | DUTY_W | Duty-cycle ceiling |
| pwr_good | output | 1 | Power-good flag |

## Verification
The bench keeps a cycle count of its own and compares all four outputs on every clock. A wrong tick count or a wrong interval boundary therefore shows within one tick, as a mode code that changes one cycle early or late, or as a ramp value that is off by one step. A supply-ready or enable-edge state that is latched wrongly shows as a run that starts, or fails to start, on the clock after the stimulus. A missed abort shows as a non-zero mode or a power-good level that lingers one clock after the enable rises or the supply drops.

// File: rtl/softstart_pkg.sv
package softstart_pkg;
   typedef enum logic [1:0] {
      MODE_HIZ = 2'b00,
      MODE_LOW = 2'b01,
      MODE_PWM = 2'b10
   } ph_mode_t;
endpackage

// File: rtl/ss_supply_gate.sv
module ss_supply_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic sup_above_rise,
   input  logic sup_below_fall,
   input  logic en_n,
   output logic start,
   output logic abort
);
   logic supply_ok;
   logic en_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         supply_ok <= 1'b0;
         en_prev   <= 1'b0;
      end else begin
         if (sup_below_fall)      supply_ok <= 1'b0;
         else if (sup_above_rise) supply_ok <= 1'b1;
         en_prev <= en_n;
      end
   end

   assign start = supply_ok & en_prev & ~en_n & ~sup_below_fall;
   assign abort = en_n | ~supply_ok | sup_below_fall;
endmodule

// File: rtl/ss_cycle_count.sv
module ss_cycle_count #(
   parameter int LIMIT = 4096,
   parameter int CNT_W = $clog2(LIMIT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start,
   input  logic             abort,
   output logic             running,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt     <= '0;
      end else if (!running) begin
         if (start) begin
            running <= 1'b1;
            cnt     <= '0;
         end
      end else if (abort) begin
         running <= 1'b0;
         cnt     <= '0;
      end else if (tick && cnt < CNT_TOP) begin
         cnt <= cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/ss_ramp.sv
module ss_ramp #(
   parameter int CNT_W  = 13,
   parameter int START  = 364,
   parameter int SHIFT  = 3,
   parameter int OUT_W  = 8
) (
   input  logic             running,
   input  logic [CNT_W-1:0] cnt,
   output logic [OUT_W-1:0] value
);
   localparam logic [CNT_W-1:0] START_C = CNT_W'(START);
   localparam logic [CNT_W-1:0] FULL_C  = CNT_W'((1 << OUT_W) - 1);

   if (CNT_W <= OUT_W) begin : g_bad_width
      $error("ss_ramp: counter must be wider than the output");
   end

   logic [CNT_W-1:0] elapsed;
   logic [CNT_W-1:0] scaled;

   always_comb begin
      elapsed = cnt - START_C;
      scaled  = elapsed >> SHIFT;
      if (!running || cnt < START_C) value = '0;
      else if (scaled > FULL_C)       value = FULL_C[OUT_W-1:0];
      else                            value = scaled[OUT_W-1:0];
   end
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
   import softstart_pkg::*;
#(
   parameter int NPH        = 2,
   parameter int HIZ_CYC    = 64,
   parameter int CLAMP_CYC  = 300,
   parameter int PG_CYC     = 4096,
   parameter int REF_W      = 8,
   parameter int REF_SHIFT  = 3,
   parameter int DUTY_W     = 6,
   parameter int DUTY_SHIFT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              sup_above_rise,
   input  logic              sup_below_fall,
   input  logic              en_n,
   output logic [2*NPH-1:0]  ph_mode,
   output logic [REF_W-1:0]  ref_code,
   output logic [DUTY_W-1:0] duty_max,
   output logic              pwr_good
);
   localparam int CNT_W      = $clog2(PG_CYC + 1);
   localparam int RAMP_START = HIZ_CYC + CLAMP_CYC;
   localparam int REF_END    = RAMP_START + (((1 << REF_W) - 1) << REF_SHIFT);
   localparam int DUTY_END   = RAMP_START + (((1 << DUTY_W) - 1) << DUTY_SHIFT);
   localparam logic [CNT_W-1:0] HIZ_END_C  = CNT_W'(HIZ_CYC);
   localparam logic [CNT_W-1:0] RAMP_C     = CNT_W'(RAMP_START);
   localparam logic [CNT_W-1:0] PG_C       = CNT_W'(PG_CYC);

   if (NPH < 1) begin : g_bad_nph
      $error("softstart_seq: NPH must be at least 1");
   end
   if (REF_END >= PG_CYC) begin : g_bad_ref
      $error("softstart_seq: reference ramp does not finish before power-good");
   end
   if (DUTY_END >= PG_CYC) begin : g_bad_duty
      $error("softstart_seq: duty ramp does not finish before power-good");
   end

   logic             start;
   logic             abort;
   logic             running;
   logic [CNT_W-1:0] cnt;
   ph_mode_t         mode_now;

   ss_supply_gate u_gate (
      .clk            (clk),
      .rst_n          (rst_n),
      .sup_above_rise (sup_above_rise),
      .sup_below_fall (sup_below_fall),
      .en_n           (en_n),
      .start          (start),
      .abort          (abort)
   );

   ss_cycle_count #(.LIMIT(PG_CYC), .CNT_W(CNT_W)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .start   (start),
      .abort   (abort),
      .running (running),
      .cnt     (cnt)
   );

   ss_ramp #(.CNT_W(CNT_W), .START(RAMP_START), .SHIFT(REF_SHIFT), .OUT_W(REF_W)) u_ref_ramp (
      .running (running),
      .cnt     (cnt),
      .value   (ref_code)
   );

   ss_ramp #(.CNT_W(CNT_W), .START(RAMP_START), .SHIFT(DUTY_SHIFT), .OUT_W(DUTY_W)) u_duty_ramp (
      .running (running),
      .cnt     (cnt),
      .value   (duty_max)
   );

   always_comb begin
      if (!running || cnt < HIZ_END_C) mode_now = MODE_HIZ;
      else if (cnt < RAMP_C)           mode_now = MODE_LOW;
      else                             mode_now = MODE_PWM;
   end

   for (genvar p = 0; p < NPH; p++) begin : g_phase
      assign ph_mode[2*p +: 2] = mode_now;
   end

   assign pwr_good = running && (cnt >= PG_C);
endmodule

// File: rtl/softstart_seq_chk.sv
module softstart_seq_chk #(
   parameter int NPH    = 2,
   parameter int REF_W  = 8,
   parameter int DUTY_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sup_below_fall,
   input logic              en_n,
   input logic [2*NPH-1:0]  ph_mode,
   input logic [REF_W-1:0]  ref_code,
   input logic [DUTY_W-1:0] duty_max,
   input logic              pwr_good
);
   AST_SUPPLY_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      sup_below_fall |=> (ph_mode == '0 && !pwr_good)); // R2
   AST_ENABLE_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      en_n |=> (ph_mode == '0 && !pwr_good && ref_code == '0)); // R10
   AST_RAMPS_ONLY_SWITCHING: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_mode[1:0] != 2'b10) |-> (ref_code == '0 && duty_max == '0)); // R4
   AST_PHASES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_mode == {NPH{ph_mode[1:0]}}) && (ph_mode[1:0] != 2'b11)); // R6
   AST_REF_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(ref_code) && ref_code != '0) |-> (ref_code == $past(ref_code) + REF_W'(1))); // R7
   AST_PG_FULL_REF: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_good |-> (ref_code == '1 && ph_mode[1:0] == 2'b10)); // R9
endmodule

bind softstart_seq softstart_seq_chk #(.NPH(NPH), .REF_W(REF_W), .DUTY_W(DUTY_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .sup_below_fall (sup_below_fall),
   .en_n           (en_n),
   .ph_mode        (ph_mode),
   .ref_code       (ref_code),
   .duty_max       (duty_max),
   .pwr_good       (pwr_good)
);

// File: tb/test_softstart_seq.sv
`timescale 1ns/1ps
module test_softstart_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       tick_on = 1'b0;
   logic       sup_above_rise = 1'b0;
   logic       sup_below_fall = 1'b0;
   logic       en_n = 1'b1;
   logic [3:0] ph_mode;
   logic [7:0] ref_code;
   logic [5:0] duty_max;
   logic       pwr_good;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   // reference model state
   bit m_sup, m_prev, m_run;
   int m_k;

   always #5 clk = ~clk;

   softstart_seq i_softstart_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .sup_above_rise(sup_above_rise), .sup_below_fall(sup_below_fall),
      .en_n(en_n), .ph_mode(ph_mode), .ref_code(ref_code),
      .duty_max(duty_max), .pwr_good(pwr_good)
   );

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   function automatic int sat(int v, int top);
      return (v > top) ? top : v;
   endfunction

   // tick every other clock while enabled
   always @(negedge clk) begin
      cycles++;
      tick <= tick_on && !tick;
   end

   // behavioural model: advance on each rising edge using the inputs present there
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sup = 0; m_prev = 0; m_run = 0; m_k = 0;
      end else begin
         if (m_run) begin
            if (en_n || sup_below_fall || !m_sup) begin m_run = 0; m_k = 0; end
            else if (tick && m_k < 4096) m_k++;
         end else if (m_prev && !en_n && m_sup && !sup_below_fall) begin
            m_run = 1; m_k = 0;
         end
         if (sup_below_fall) m_sup = 0;
         else if (sup_above_rise) m_sup = 1;
         m_prev = en_n;
      end
   end

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         int em, er, ed, ep;
         string mt;
         em = 0; er = 0; ed = 0; ep = 0; mt = "R1";
         if (m_run) begin
            if (m_k < 64) begin em = 0; mt = "R4"; end
            else if (m_k < 364) begin em = 1; mt = "R5"; end
            else begin
               em = 2; mt = "R6";
               er = sat((m_k - 364) >> 3, 255);
               ed = sat((m_k - 364) >> 4, 63);
            end
            ep = (m_k >= 4096) ? 1 : 0;
         end
         check(mt, int'(ph_mode), em * 5);
         check("R7", int'(ref_code), er);
         check("R8", int'(duty_max), ed);
         check("R9", int'(pwr_good), ep);
      end
   end

   task automatic clocks(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_rise();
      sup_above_rise = 1'b1; clocks(1); sup_above_rise = 1'b0;
   endtask

   initial begin
      clocks(3);
      check("R1", int'(ph_mode), 0);
      check("R1", int'(ref_code) + int'(duty_max) + int'(pwr_good), 0);
      rst_n = 1'b1;
      clocks(1);
      check("R1", int'(ph_mode), 0);
      tick_on = 1'b1;

      // enable low before supply ready: no run (R3)
      en_n = 1'b0;
      clocks(2);
      pulse_rise();
      clocks(300);
      check("R3", int'(ph_mode), 0);

      // falling edge with supply ready: full run (R4 R5 R6 R7 R8 R9 R11)
      en_n = 1'b1; clocks(2);
      en_n = 1'b0;
      clocks(8400);
      check("R9", int'(pwr_good), 1);
      check("R7", int'(ref_code), 255);
      check("R8", int'(duty_max), 63);

      // ticks stop: counter holds in clamp (R11)
      en_n = 1'b1; clocks(1);
      check("R10", int'(pwr_good) + int'(ph_mode), 0);
      en_n = 1'b0;
      clocks(200);
      tick_on = 1'b0;
      clocks(50);
      check("R11", int'(ph_mode), 5);
      clocks(500);
      check("R11", int'(ph_mode), 5);
      tick_on = 1'b1;

      // run into ramp then raise enable (R10)
      clocks(1000);
      check("R6", int'(ph_mode), 10);
      en_n = 1'b1; clocks(1);
      check("R10", int'(ph_mode) + int'(ref_code), 0);

      // supply drop during a run (R2)
      en_n = 1'b0;
      clocks(400);
      sup_below_fall = 1'b1; clocks(1); sup_below_fall = 1'b0;
      check("R2", int'(ph_mode), 0);
      en_n = 1'b1; clocks(2); en_n = 1'b0;
      clocks(300);
      check("R2", int'(ph_mode), 0);

      // rise and fall flags together: fall wins (R2)
      sup_above_rise = 1'b1; sup_below_fall = 1'b1; clocks(1);
      sup_above_rise = 1'b0; sup_below_fall = 1'b0;
      en_n = 1'b1; clocks(2); en_n = 1'b0;
      clocks(300);
      check("R2", int'(ph_mode), 0);

      // supply ready again, fresh edge starts a run (R3)
      pulse_rise();
      en_n = 1'b1; clocks(2); en_n = 1'b0;
      clocks(300);
      check("R3", int'(ph_mode), 5);
      clocks(20);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule